// File: doc/BRIEF.md
# Multi-Bank Clock Divider with Alignment Pulse

This block turns one fast source clock into three banks of four divided clock outputs, a separately divided feedback clock, and a short alignment pulse. An optional halving stage sits in front of every divider. Each bank takes its own 2-bit ratio code. The feedback divider takes a 3-bit code. All dividers count enable ticks in the source clock domain, so every output changes only on a source clock edge.

The alignment pulse marks the points where bank A and bank C both start a new period together, whatever ratios they run at. A bank ratio change waits for the next such point, so the two banks stay phase-aligned. Two outputs of bank C can be inverted. A 12-bit enable word is loaded one bit at a time through a slow serial clock and data pair, and it can switch any output off individually. An active-low master reset clears the block and holds every output low.

Top module: `clkbank_gen`

## Requirements
- R1: When `vco_direct` is high, every divider advances once per source clock cycle. When it is low, every divider advances once every second cycle, so every output period and high time doubles.
- R2: Bank ratio codes select divide-by 0→2, 1→4, 2→6, 3→8, counted in divider advances. Each bank output is high for the first half of its period and low for the second half.
- R3: Feedback codes 0 to 7 select divide-by 4, 6, 8, 10, 12, 16, 20, 24, counted in divider advances. The duty cycle is 50 %.
- R4: `sync_out` is high for exactly one source clock cycle. It repeats every lcm(ratio A, ratio C) divider advances. In every cycle where it is high, the uninverted enabled outputs of banks A and C are high, and they were low in the cycle before.
- R5: While `invert_c` is high, `qc[2]` and `qc[3]` carry the inverse of the bank C waveform. `qc[0]` and `qc[1]` are never inverted.
- R6: While `mreset_n` is low, all outputs are low, all counters are cleared, and the ratio codes presented are captured as the active ones. In the first cycle after release, every enabled bank output, `fb_out` and `sync_out` are high.
- R7: Each rising edge of the sampled `sclk` shifts `sdata` into bit 0 of a 12-bit enable word and moves the older bits up one place. After 12 edges, the first bit sent sits in bit 11. Bit i gates output i: bits 0–3 are `qa[0..3]`, bits 4–7 are `qb[0..3]`, bits 8–11 are `qc[0..3]`. A 1 enables the output. A 0 holds it low, including after inversion. Master reset sets the word to all ones.
- R8: A bank ratio code change takes effect only on the advance that completes the current alignment period. Until then the old ratio keeps running. A bank whose code changed restarts its count at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| mreset_n | input | 1 | Synchronous active-low master reset and output disable |
| vco_direct | input | 1 | 1: no pre-divide, 0: pre-divide by 2 |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| fb_sel | input | 3 | Feedback ratio code |
| invert_c | input | 1 | Invert bank C outputs 2 and 3 |
| sclk | input | 1 | Serial load clock, sampled by clk |
| sdata | input | 1 | Serial enable data |
| qa | output | 4 | Bank A outputs |
| qb | output | 4 | Bank B outputs |
| qc | output | 4 | Bank C outputs |
| fb_out | output | 1 | Feedback divider output |
| sync_out | output | 1 | Alignment pulse |

## Verification
The bench builds the block with its default parameters: three banks of four outputs, 5-bit counters, and a two-stage sampler on the serial pair. With these values every bank code and every feedback code can be reached, up to divide-by-24. Divide-by-24 is also the longest alignment span, the one reached with bank A at /8 and bank C at /6. Whole periods of these outputs, with the pre-divider on or off, fit in a short sampling window, so each period and each high time is measured directly. All twelve enable bits can be cleared and restored, including the inverted bank C pair.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    localparam int NUM_BANKS = 3;
    localparam int BANK_OUTS = 4;
    localparam int SEL_W     = 2;
    localparam int FB_SEL_W  = 3;
    localparam int CNT_W     = 5;
    localparam int EN_W      = NUM_BANKS * BANK_OUTS;

    typedef logic [SEL_W-1:0]    bank_sel_t;
    typedef logic [FB_SEL_W-1:0] fb_sel_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    // divide ratio of a bank: 2 * (code + 1)
    function automatic cnt_t bank_ratio(bank_sel_t s);
        return cnt_t'({s, 1'b0}) + cnt_t'(2);
    endfunction

    function automatic cnt_t fb_ratio(fb_sel_t s);
        case (s)
            3'd0:    return cnt_t'(4);
            3'd1:    return cnt_t'(6);
            3'd2:    return cnt_t'(8);
            3'd3:    return cnt_t'(10);
            3'd4:    return cnt_t'(12);
            3'd5:    return cnt_t'(16);
            3'd6:    return cnt_t'(20);
            default: return cnt_t'(24);
        endcase
    endfunction

    // least common multiple of two bank ratios (values 2, 4, 6, 8)
    function automatic cnt_t sync_span(bank_sel_t sa, bank_sel_t sc);
        cnt_t na;
        cnt_t nc;
        na = bank_ratio(sa);
        nc = bank_ratio(sc);
        if ((na % nc) == '0) return na;
        if ((nc % na) == '0) return nc;
        // only the pairs {4,6} and {6,8} remain
        if (na == cnt_t'(8) || nc == cnt_t'(8)) return cnt_t'(24);
        return cnt_t'(12);
    endfunction

endpackage

// File: rtl/clkbank_prediv.sv
module clkbank_prediv (
    input  logic clk,
    input  logic mreset_n,
    input  logic bypass,
    output logic tick,
    output logic fresh
);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (!mreset_n)   phase_q <= 1'b0;
        else if (bypass) phase_q <= 1'b0;
        else             phase_q <= ~phase_q;
    end

    // tick: counters advance at the coming edge
    // fresh: counters changed at the previous edge
    assign tick  = bypass | phase_q;
    assign fresh = bypass | ~phase_q;

    p_half_rate_r1: assert property (@(posedge clk) disable iff (!mreset_n)
        (!bypass && tick) |=> (bypass || !tick));

endmodule

// File: rtl/clkbank_divider.sv
module clkbank_divider
    import clkbank_pkg::*;
(
    input  logic      clk,
    input  logic      mreset_n,
    input  logic      tick,
    input  logic      apply,
    input  bank_sel_t sel_req,
    output bank_sel_t sel_cur,
    output logic      wave
);

    cnt_t      cnt_q;
    bank_sel_t sel_q;
    cnt_t      last;

    assign last = bank_ratio(sel_q) - cnt_t'(1);

    always_ff @(posedge clk) begin
        if (!mreset_n) begin
            cnt_q <= '0;
            sel_q <= sel_req;
        end else if (apply && (sel_req != sel_q)) begin
            cnt_q <= '0;
            sel_q <= sel_req;
        end else if (tick) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + cnt_t'(1);
        end
    end

    assign sel_cur = sel_q;
    assign wave    = (cnt_q <= cnt_t'(sel_q));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!mreset_n)
        cnt_q <= last);

endmodule

// File: rtl/clkbank_fbdiv.sv
module clkbank_fbdiv
    import clkbank_pkg::*;
(
    input  logic    clk,
    input  logic    mreset_n,
    input  logic    tick,
    input  fb_sel_t sel,
    output logic    wave
);

    cnt_t cnt_q;
    cnt_t ratio;
    cnt_t last;

    assign ratio = fb_ratio(sel);
    assign last  = ratio - cnt_t'(1);

    always_ff @(posedge clk) begin
        if (!mreset_n)  cnt_q <= '0;
        else if (tick)  cnt_q <= (cnt_q >= last) ? '0 : cnt_q + cnt_t'(1);
    end

    assign wave = (cnt_q < (ratio >> 1));

    p_fb_wrap_r3: assert property (@(posedge clk) disable iff (!mreset_n)
        (tick && cnt_q >= last) |=> (cnt_q == '0));

endmodule

// File: rtl/clkbank_serial.sv
module clkbank_serial
    import clkbank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            mreset_n,
    input  logic            sclk,
    input  logic            sdata,
    output logic [EN_W-1:0] enable
);

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] sdata_pipe;
    logic              sclk_last;
    logic [EN_W-1:0]   en_q;
    logic              rise;
    logic              bit_in;

    assign rise   = sclk_pipe[STAGES-1] & ~sclk_last;
    assign bit_in = sdata_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (!mreset_n) begin
            sclk_pipe  <= '0;
            sdata_pipe <= '0;
            sclk_last  <= 1'b0;
            en_q       <= '1;
        end else begin
            sclk_pipe  <= {sclk_pipe[STAGES-2:0], sclk};
            sdata_pipe <= {sdata_pipe[STAGES-2:0], sdata};
            sclk_last  <= sclk_pipe[STAGES-1];
            if (rise) en_q <= {en_q[EN_W-2:0], bit_in};
        end
    end

    assign enable = en_q;

    p_en_hold_r7: assert property (@(posedge clk) disable iff (!mreset_n)
        (mreset_n && !rise) |=> $stable(en_q));

    p_shift_in_r7: assert property (@(posedge clk) disable iff (!mreset_n)
        (mreset_n && rise) |=> (en_q[0] == $past(bit_in)));

endmodule

// File: rtl/clkbank_gen.sv
module clkbank_gen
    import clkbank_pkg::*;
#(
    parameter int SCLK_STAGES = 2
) (
    input  logic                clk,
    input  logic                mreset_n,
    input  logic                vco_direct,
    input  logic [SEL_W-1:0]    sel_a,
    input  logic [SEL_W-1:0]    sel_b,
    input  logic [SEL_W-1:0]    sel_c,
    input  logic [FB_SEL_W-1:0] fb_sel,
    input  logic                invert_c,
    input  logic                sclk,
    input  logic                sdata,
    output logic [BANK_OUTS-1:0] qa,
    output logic [BANK_OUTS-1:0] qb,
    output logic [BANK_OUTS-1:0] qc,
    output logic                fb_out,
    output logic                sync_out
);

    localparam int IDX_A = 0;
    localparam int IDX_C = NUM_BANKS - 1;

    logic            tick;
    logic            fresh;
    bank_sel_t       req [NUM_BANKS];
    bank_sel_t       cur [NUM_BANKS];
    logic [NUM_BANKS-1:0] wave;
    logic [EN_W-1:0] raw;
    logic [EN_W-1:0] enable;
    logic [EN_W-1:0] gated;
    logic            fb_wave;
    cnt_t            span;
    cnt_t            sync_cnt_q;
    logic            apply;

    assign req[0] = sel_a;
    assign req[1] = sel_b;
    assign req[2] = sel_c;

    clkbank_prediv u_prediv (
        .clk      (clk),
        .mreset_n (mreset_n),
        .bypass   (vco_direct),
        .tick     (tick),
        .fresh    (fresh)
    );

    // alignment span counter over bank A and bank C
    assign span  = sync_span(cur[IDX_A], cur[IDX_C]);
    assign apply = tick && (sync_cnt_q == span - cnt_t'(1));

    always_ff @(posedge clk) begin
        if (!mreset_n)  sync_cnt_q <= '0;
        else if (apply) sync_cnt_q <= '0;
        else if (tick)  sync_cnt_q <= sync_cnt_q + cnt_t'(1);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        clkbank_divider u_div (
            .clk      (clk),
            .mreset_n (mreset_n),
            .tick     (tick),
            .apply    (apply),
            .sel_req  (req[b]),
            .sel_cur  (cur[b]),
            .wave     (wave[b])
        );
        for (genvar o = 0; o < BANK_OUTS; o++) begin : g_out
            localparam bit FLIP = (b == IDX_C) && (o >= BANK_OUTS / 2);
            assign raw[b*BANK_OUTS + o] = wave[b] ^ (FLIP & invert_c);
        end
    end

    clkbank_fbdiv u_fbdiv (
        .clk      (clk),
        .mreset_n (mreset_n),
        .tick     (tick),
        .sel      (fb_sel),
        .wave     (fb_wave)
    );

    clkbank_serial #(.STAGES(SCLK_STAGES)) u_serial (
        .clk      (clk),
        .mreset_n (mreset_n),
        .sclk     (sclk),
        .sdata    (sdata),
        .enable   (enable)
    );

    assign gated    = raw & enable & {EN_W{mreset_n}};
    assign qa       = gated[0*BANK_OUTS +: BANK_OUTS];
    assign qb       = gated[1*BANK_OUTS +: BANK_OUTS];
    assign qc       = gated[2*BANK_OUTS +: BANK_OUTS];
    assign fb_out   = fb_wave & mreset_n;
    assign sync_out = mreset_n & fresh & (sync_cnt_q == '0);

    p_sync_align_r4: assert property (@(posedge clk) disable iff (!mreset_n)
        sync_out |-> (wave[IDX_A] && wave[IDX_C]));

    p_sync_width_r4: assert property (@(posedge clk) disable iff (!mreset_n)
        sync_out |=> !sync_out);

    p_invert_r5: assert property (@(posedge clk) disable iff (!mreset_n)
        (invert_c && enable[2*BANK_OUTS + 2]) |-> (qc[2] == !wave[IDX_C]));

    p_reset_quiet_r6: assert property (@(posedge clk)
        !mreset_n |-> (qa == '0 && qb == '0 && qc == '0 && !fb_out && !sync_out));

    p_gate_r7: assert property (@(posedge clk) disable iff (!mreset_n)
        ((qa & ~enable[0 +: BANK_OUTS]) == '0));

    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!mreset_n)
        (mreset_n && !apply) |=> $stable({cur[0], cur[1], cur[2]}));

endmodule

// File: tb/clkbank_gen_bench.sv
module clkbank_gen_bench;

    localparam int NS = 200;

    logic       clk = 1'b0;
    logic       mreset_n = 1'b0;
    logic       vco_direct = 1'b1;
    logic [1:0] sel_a = 2'd0;
    logic [1:0] sel_b = 2'd0;
    logic [1:0] sel_c = 2'd0;
    logic [2:0] fb_sel = 3'd0;
    logic       invert_c = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [3:0] qa, qb, qc;
    logic       fb_out, sync_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [13:0] smp [NS];

    always #4 clk = ~clk;

    clkbank_gen u_clkbank_gen (
        .clk(clk), .mreset_n(mreset_n), .vco_direct(vco_direct),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .fb_sel(fb_sel),
        .invert_c(invert_c), .sclk(sclk), .sdata(sdata),
        .qa(qa), .qb(qb), .qc(qc), .fb_out(fb_out), .sync_out(sync_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reset with a configuration, release at a falling edge
    task automatic setup(input logic vco, input logic [1:0] sa, input logic [1:0] sb,
                         input logic [1:0] sc, input logic [2:0] fb, input logic inv);
        @(negedge clk);
        mreset_n = 1'b0;
        vco_direct = vco; sel_a = sa; sel_b = sb; sel_c = sc;
        fb_sel = fb; invert_c = inv;
        cyc(3);
        mreset_n = 1'b1;
    endtask

    task automatic sample_run();
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            smp[i] = {sync_out, fb_out, qc, qb, qa};
        end
    endtask

    task automatic analyze(input int idx, output int per, output int hi);
        int r1 = -1, r2 = -1, f = -1;
        for (int i = 1; i < NS; i++) begin
            if (!smp[i-1][idx] && smp[i][idx]) begin
                if (r1 < 0) r1 = i;
                else if (r2 < 0) r2 = i;
            end
            if (r1 >= 0 && f < 0 && smp[i-1][idx] && !smp[i][idx]) f = i;
        end
        per = (r1 >= 0 && r2 >= 0) ? r2 - r1 : -1;
        hi  = (r1 >= 0 && f >= 0) ? f - r1 : -1;
    endtask

    task automatic expect_wave(input int idx, input int per_exp, input int hi_exp, input string tag);
        int per, hi;
        analyze(idx, per, hi);
        check(per == per_exp, {tag, " period"}, per, per_exp);
        check(hi == hi_exp, {tag, " high time"}, hi, hi_exp);
    endtask

    task automatic t_reset();
        int bad = 0;
        @(negedge clk);
        mreset_n = 1'b0;
        vco_direct = 1'b1; sel_a = 2'd3; sel_b = 2'd1; sel_c = 2'd2; fb_sel = 3'd2; invert_c = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if ({qa, qb, qc, fb_out, sync_out} != '0) bad++;
        end
        check(bad == 0, "R6 outputs low in reset", bad, 0);
        mreset_n = 1'b1;
        #1;
        check({qa, qb, qc} == 12'hFFF, "R6 banks high after release", int'({qa, qb, qc}), 12'hFFF);
        check(fb_out && sync_out, "R6 fb and sync high after release", int'({fb_out, sync_out}), 3);
        sample_run();
        expect_wave(0, 8, 4, "R6 captured ratio qa0");
    endtask

    task automatic t_bank_ratios();
        for (int s = 0; s < 4; s++) begin
            setup(1'b1, 2'(s), 2'(3 - s), 2'(s), 3'd0, 1'b0);
            sample_run();
            expect_wave(0, 2 * (s + 1), s + 1, "R2 bank A");
            expect_wave(7, 2 * (4 - s), 4 - s, "R2 bank B");
            expect_wave(9, 2 * (s + 1), s + 1, "R2 bank C");
        end
    endtask

    task automatic t_prediv();
        setup(1'b0, 2'd2, 2'd1, 2'd0, 3'd1, 1'b0);
        sample_run();
        expect_wave(0, 12, 6, "R1 halved bank A");
        expect_wave(4, 8, 4, "R1 halved bank B");
        expect_wave(12, 12, 6, "R1 halved feedback");
    endtask

    task automatic t_feedback();
        int ratio [8] = '{4, 6, 8, 10, 12, 16, 20, 24};
        for (int c = 0; c < 8; c++) begin
            setup(1'b1, 2'd0, 2'd0, 2'd0, 3'(c), 1'b0);
            sample_run();
            expect_wave(12, ratio[c], ratio[c] / 2, "R3 feedback");
        end
    endtask

    task automatic sync_case(input logic vco, input logic [1:0] sa, input logic [1:0] sc, input int per_exp);
        int bad = 0, seen = 0;
        setup(vco, sa, 2'd0, sc, 3'd0, 1'b0);
        sample_run();
        expect_wave(13, per_exp, 1, "R4 sync");
        for (int i = 1; i < NS; i++) begin
            if (smp[i][13]) begin
                seen++;
                if (!(smp[i][0] && smp[i][8] && !smp[i-1][0] && !smp[i-1][8])) bad++;
            end
        end
        check(seen > 0 && bad == 0, "R4 sync on common rising edge", bad, 0);
    endtask

    task automatic t_sync();
        sync_case(1'b1, 2'd1, 2'd2, 12);
        sync_case(1'b0, 2'd1, 2'd2, 24);
        sync_case(1'b1, 2'd3, 2'd2, 24);
        sync_case(1'b1, 2'd0, 2'd3, 8);
    endtask

    task automatic t_invert();
        int bad = 0;
        setup(1'b1, 2'd0, 2'd0, 2'd1, 3'd0, 1'b1);
        sample_run();
        for (int i = 0; i < NS; i++)
            if (smp[i][9] != smp[i][8] || smp[i][10] == smp[i][8] || smp[i][11] == smp[i][8]) bad++;
        check(bad == 0, "R5 qc2 qc3 inverted, qc0 qc1 not", bad, 0);
        setup(1'b1, 2'd0, 2'd0, 2'd1, 3'd0, 1'b0);
        sample_run();
        bad = 0;
        for (int i = 0; i < NS; i++)
            if (smp[i][10] != smp[i][8] || smp[i][11] != smp[i][8]) bad++;
        check(bad == 0, "R5 no inversion when invert_c low", bad, 0);
    endtask

    task automatic t_serial();
        logic [11:0] pat;
        int per, hi, hi1, hi10;
        pat = 12'hFFF & ~12'h002 & ~12'h400;
        setup(1'b1, 2'd1, 2'd1, 2'd1, 3'd0, 1'b1);
        for (int i = 11; i >= 0; i--) begin
            sdata = pat[i];
            cyc(3); sclk = 1'b1;
            cyc(3); sclk = 1'b0;
            cyc(3);
        end
        sample_run();
        hi1 = 0; hi10 = 0;
        for (int i = 0; i < NS; i++) begin
            if (smp[i][1]) hi1++;
            if (smp[i][10]) hi10++;
        end
        check(hi1 == 0, "R7 qa1 disabled held low", hi1, 0);
        check(hi10 == 0, "R7 inverted qc2 disabled held low", hi10, 0);
        analyze(0, per, hi);
        check(per == 4, "R7 qa0 still enabled", per, 4);
        analyze(11, per, hi);
        check(per == 4, "R7 qc3 still enabled", per, 4);
        setup(1'b1, 2'd1, 2'd1, 2'd1, 3'd0, 1'b1);
        sample_run();
        analyze(1, per, hi);
        check(per == 4, "R7 reset re-enables qa1", per, 4);
    endtask

    task automatic t_apply();
        int bad = 0, guard = 0;
        setup(1'b1, 2'd3, 2'd0, 2'd3, 3'd0, 1'b0);
        cyc(1);
        while (!sync_out && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check(sync_out == 1'b1, "R8 found alignment point", int'(sync_out), 1);
        sel_a = 2'd0;
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            if (qa[0] != (k < 4)) bad++;
        end
        check(bad == 0, "R8 old ratio kept until alignment point", bad, 0);
        @(negedge clk);
        check(sync_out && qa[0], "R8 new period starts at alignment", int'({sync_out, qa[0]}), 3);
        @(negedge clk);
        check(qa[0] == 1'b0, "R8 new ratio /2 low half", int'(qa[0]), 0);
        @(negedge clk);
        check(qa[0] == 1'b1, "R8 new ratio /2 next rise", int'(qa[0]), 1);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bank_ratios();
        t_prediv();
        t_feedback();
        t_sync();
        t_invert();
        t_serial();
        t_apply();
        done = 1'b1;
        report();
        $finish;
    end

endmodule